// File: doc/BRIEF.md
# Translation Lookaside Unit with Single-Level Table Walk

This block turns 16-bit virtual addresses into 16-bit physical addresses for a cache miss path. The top four bits select one of sixteen 4 KB virtual pages. The low twelve bits pass through unchanged. Translations are cached in a small fully associative array with least-recently-used replacement. A request whose page is cached is answered on the next cycle.

When a request misses the array, the block walks a one-level page table with sixteen entries, indexed by the virtual page number. The walk takes a fixed number of cycles. If the table entry is valid, its physical page number is returned and installed over the least recently used slot. Empty slots are always the oldest, so they are filled first. If the table entry is invalid, the block answers with a page fault and caches nothing.

The table is loaded through a simple write port. Two counters report how many responses came from the array and how many came from walks.

Top module: `xlat_tlb`

## Requirements
- R1: After reset the array holds no translation, `rsp_valid`, `rsp_fault` and `rsp_tlb_hit` are low, `req_ready` is high, both counters read 0, and every table entry is invalid, so a first request faults.
- R2: The virtual page number is `req_vaddr[15:12]`. A translated response carries `rsp_paddr = {ppn, req_vaddr[11:0]}`.
- R3: A request accepted (`req_valid` and `req_ready` both high at a rising edge) whose page is cached produces a one-cycle response right after that edge, with `rsp_tlb_hit`=1 and `rsp_fault`=0.
- R4: A request that misses drops `req_ready` after the accepting edge. It responds with `rsp_tlb_hit`=0, WALK_LAT edges (default 3) after the accepting edge.
- R5: A walk that finds an invalid table entry responds with `rsp_fault`=1 and installs nothing, so a repeat of the same page misses again.
- R6: A walk that finds a valid entry installs it, so the next request to that page hits.
- R7: The array holds TLB_ENTRIES (default 8) pages. Installing a page into a full array evicts the page least recently installed or hit.
- R8: A table write (`pt_wr_en`) sets the valid bit and PPN of entry `pt_wr_vpn` at the next edge. A walk that completes at the same edge as a write to the entry it reads uses the entry's previous contents.
- R9: `stat_hits` increments by one for each response with `rsp_tlb_hit`=1. `stat_misses` increments by one for each walk response, faulting or not. Both counters hold in every other cycle.
- R10: `req_valid` while `req_ready` is low is ignored: it produces no response and changes no counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pt_wr_en | input | 1 | Page table write strobe |
| pt_wr_vpn | input | 4 | Table entry to write |
| pt_wr_valid | input | 1 | Valid bit to write |
| pt_wr_ppn | input | 4 | Physical page number to write |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Request can be accepted (no walk in progress) |
| req_vaddr | input | 16 | Virtual address to translate |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_paddr | output | 16 | Physical address |
| rsp_fault | output | 1 | Page fault (invalid table entry) |
| rsp_tlb_hit | output | 1 | Response came from the array, not a walk |
| stat_hits | output | 16 | Count of array hits |
| stat_misses | output | 16 | Count of walks |

## Verification
Two functions can fall in the same cycle: a table write and the walk's read of the table. The bench sets up this collision by driving a write to the entry under walk during the final walk cycle. The entry is first invalid, then becomes valid. A correct design answers that walk with a fault, because it reads the old contents. The bench then repeats the request. The repeat must miss, since nothing was cached, and must return the newly written page. A long pseudo-random sweep over all sixteen pages is compared against an arithmetic model of the table and of recency order. This sweep checks the hit and miss sequence, latencies, addresses, faults and counters.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

   typedef enum logic [0:0] {
      WALK_IDLE = 1'b0,
      WALK_BUSY = 1'b1
   } walk_state_e;

   function automatic bit is_pow2(input int unsigned n);
      return (n != 0) && ((n & (n - 1)) == 0);
   endfunction

endpackage

// File: rtl/xlat_cam.sv
module xlat_cam #(
   parameter int N     = 8,
   parameter int VPN_W = 4,
   parameter int PPN_W = 4,
   localparam int IDX_W = $clog2(N)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [VPN_W-1:0] look_vpn,
   output logic             hit,
   output logic [IDX_W-1:0] hit_idx,
   output logic [PPN_W-1:0] hit_ppn,
   input  logic             fill_en,
   input  logic [IDX_W-1:0] fill_idx,
   input  logic [VPN_W-1:0] fill_vpn,
   input  logic [PPN_W-1:0] fill_ppn
);

   logic [N-1:0]     slot_vld;
   logic [VPN_W-1:0] slot_vpn [N];
   logic [PPN_W-1:0] slot_ppn [N];
   logic [N-1:0]     match;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         slot_vld <= '0;
         for (int i = 0; i < N; i++) begin
            slot_vpn[i] <= '0;
            slot_ppn[i] <= '0;
         end
      end else if (fill_en) begin
         slot_vld[fill_idx] <= 1'b1;
         slot_vpn[fill_idx] <= fill_vpn;
         slot_ppn[fill_idx] <= fill_ppn;
      end
   end

   for (genvar g = 0; g < N; g++) begin : g_cmp
      assign match[g] = slot_vld[g] && (slot_vpn[g] == look_vpn);
   end

   always_comb begin
      hit     = |match;
      hit_idx = '0;
      hit_ppn = '0;
      for (int i = 0; i < N; i++) begin
         if (match[i]) begin
            hit_idx = IDX_W'(i);
            hit_ppn = slot_ppn[i];
         end
      end
   end

endmodule

// File: rtl/xlat_lru.sv
module xlat_lru #(
   parameter int N = 8,
   localparam int IDX_W = $clog2(N)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             touch_en,
   input  logic [IDX_W-1:0] touch_idx,
   output logic [IDX_W-1:0] victim_idx
);

   logic [IDX_W-1:0] age [N];
   logic [IDX_W-1:0] touched_age;

   assign touched_age = age[touch_idx];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < N; i++) age[i] <= IDX_W'(i);
      end else if (touch_en) begin
         for (int i = 0; i < N; i++) begin
            if (IDX_W'(i) == touch_idx)   age[i] <= '0;
            else if (age[i] < touched_age) age[i] <= age[i] + 1'b1;
         end
      end
   end

   always_comb begin
      victim_idx = '0;
      for (int i = 0; i < N; i++) begin
         if (age[i] == IDX_W'(N - 1)) victim_idx = IDX_W'(i);
      end
   end

endmodule

// File: rtl/xlat_walker.sv
module xlat_walker
   import xlat_pkg::*;
#(
   parameter int VPN_W = 4,
   parameter int PPN_W = 4,
   parameter int LAT   = 3,
   localparam int DEPTH = 1 << VPN_W,
   localparam int CNT_W = (LAT > 1) ? $clog2(LAT) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [VPN_W-1:0] wr_vpn,
   input  logic             wr_vld,
   input  logic [PPN_W-1:0] wr_ppn,
   input  logic             start,
   input  logic [VPN_W-1:0] start_vpn,
   output logic             busy,
   output logic             done,
   output logic [VPN_W-1:0] done_vpn,
   output logic             done_vld,
   output logic [PPN_W-1:0] done_ppn
);

   logic [DEPTH-1:0] tbl_vld;
   logic [PPN_W-1:0] tbl_ppn [DEPTH];
   walk_state_e      st;
   logic [CNT_W-1:0] cnt;
   logic [VPN_W-1:0] cur_vpn;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tbl_vld <= '0;
         for (int i = 0; i < DEPTH; i++) tbl_ppn[i] <= '0;
      end else if (wr_en) begin
         tbl_vld[wr_vpn] <= wr_vld;
         tbl_ppn[wr_vpn] <= wr_ppn;
      end
   end

   assign busy     = (st == WALK_BUSY);
   assign done     = busy && (cnt == CNT_W'(LAT - 1));
   assign done_vpn = cur_vpn;
   assign done_vld = tbl_vld[cur_vpn];
   assign done_ppn = tbl_ppn[cur_vpn];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= WALK_IDLE;
         cnt     <= '0;
         cur_vpn <= '0;
      end else if (!busy) begin
         if (start) begin
            st      <= WALK_BUSY;
            cnt     <= '0;
            cur_vpn <= start_vpn;
         end
      end else if (done) begin
         st <= WALK_IDLE;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb
   import xlat_pkg::*;
#(
   parameter int VA_W        = 16,
   parameter int PA_W        = 16,
   parameter int PAGE_OFS_W  = 12,
   parameter int TLB_ENTRIES = 8,
   parameter int WALK_LAT    = 3,
   parameter int STAT_W      = 16,
   localparam int VPN_W = VA_W - PAGE_OFS_W,
   localparam int PPN_W = PA_W - PAGE_OFS_W,
   localparam int IDX_W = $clog2(TLB_ENTRIES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pt_wr_en,
   input  logic [VPN_W-1:0]  pt_wr_vpn,
   input  logic              pt_wr_valid,
   input  logic [PPN_W-1:0]  pt_wr_ppn,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [VA_W-1:0]   req_vaddr,
   output logic              rsp_valid,
   output logic [PA_W-1:0]   rsp_paddr,
   output logic              rsp_fault,
   output logic              rsp_tlb_hit,
   output logic [STAT_W-1:0] stat_hits,
   output logic [STAT_W-1:0] stat_misses
);

   if (!is_pow2(TLB_ENTRIES) || TLB_ENTRIES < 2) begin : g_bad_entries
      $error("TLB_ENTRIES must be a power of two of at least 2");
   end
   if (VPN_W < 1 || PPN_W < 1 || VPN_W > 12) begin : g_bad_split
      $error("address widths must leave page number bits on both sides");
   end
   if (WALK_LAT < 1) begin : g_bad_lat
      $error("WALK_LAT must be at least 1");
   end

   logic [VPN_W-1:0]      req_vpn;
   logic [PAGE_OFS_W-1:0] req_ofs;
   logic [PAGE_OFS_W-1:0] pend_ofs;
   logic                  look_hit;
   logic [IDX_W-1:0]      look_idx;
   logic [PPN_W-1:0]      look_ppn;
   logic [IDX_W-1:0]      victim_idx;
   logic                  wk_busy, wk_done, wk_vld;
   logic [VPN_W-1:0]      wk_vpn;
   logic [PPN_W-1:0]      wk_ppn;
   logic                  accept, hit_acc, miss_acc, fill_en, touch_en;
   logic [IDX_W-1:0]      touch_idx;

   assign req_vpn   = req_vaddr[VA_W-1:PAGE_OFS_W];
   assign req_ofs   = req_vaddr[PAGE_OFS_W-1:0];
   assign req_ready = !wk_busy;
   assign accept    = req_valid && !wk_busy;
   assign hit_acc   = accept && look_hit;
   assign miss_acc  = accept && !look_hit;
   assign fill_en   = wk_done && wk_vld;
   assign touch_en  = hit_acc || fill_en;
   assign touch_idx = hit_acc ? look_idx : victim_idx;

   xlat_cam #(.N(TLB_ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_cam (
      .clk      (clk),
      .rst_n    (rst_n),
      .look_vpn (req_vpn),
      .hit      (look_hit),
      .hit_idx  (look_idx),
      .hit_ppn  (look_ppn),
      .fill_en  (fill_en),
      .fill_idx (victim_idx),
      .fill_vpn (wk_vpn),
      .fill_ppn (wk_ppn)
   );

   xlat_lru #(.N(TLB_ENTRIES)) u_lru (
      .clk        (clk),
      .rst_n      (rst_n),
      .touch_en   (touch_en),
      .touch_idx  (touch_idx),
      .victim_idx (victim_idx)
   );

   xlat_walker #(.VPN_W(VPN_W), .PPN_W(PPN_W), .LAT(WALK_LAT)) u_walk (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (pt_wr_en),
      .wr_vpn    (pt_wr_vpn),
      .wr_vld    (pt_wr_valid),
      .wr_ppn    (pt_wr_ppn),
      .start     (miss_acc),
      .start_vpn (req_vpn),
      .busy      (wk_busy),
      .done      (wk_done),
      .done_vpn  (wk_vpn),
      .done_vld  (wk_vld),
      .done_ppn  (wk_ppn)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid   <= 1'b0;
         rsp_tlb_hit <= 1'b0;
         rsp_fault   <= 1'b0;
         rsp_paddr   <= '0;
         pend_ofs    <= '0;
         stat_hits   <= '0;
         stat_misses <= '0;
      end else begin
         rsp_valid   <= hit_acc || wk_done;
         rsp_tlb_hit <= hit_acc;
         rsp_fault   <= wk_done && !wk_vld;
         if (hit_acc)      rsp_paddr <= {look_ppn, req_ofs};
         else if (wk_done) rsp_paddr <= {wk_ppn, pend_ofs};
         if (miss_acc) pend_ofs <= req_ofs;
         if (hit_acc)  stat_hits   <= stat_hits + 1'b1;
         if (wk_done)  stat_misses <= stat_misses + 1'b1;
      end
   end

endmodule

// File: rtl/xlat_tlb_chk.sv
module xlat_tlb_chk #(
   parameter int VA_W       = 16,
   parameter int PA_W       = 16,
   parameter int PAGE_OFS_W = 12,
   parameter int STAT_W     = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic [VA_W-1:0]   req_vaddr,
   input logic              rsp_valid,
   input logic [PA_W-1:0]   rsp_paddr,
   input logic              rsp_fault,
   input logic              rsp_tlb_hit,
   input logic [STAT_W-1:0] stat_hits,
   input logic [STAT_W-1:0] stat_misses
);

   AST_HIT_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_tlb_hit |-> rsp_paddr[PAGE_OFS_W-1:0] == $past(req_vaddr[PAGE_OFS_W-1:0])); // R2

   AST_HIT_FOLLOWS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_tlb_hit |-> $past(req_valid && req_ready)); // R3

   AST_ACCEPT_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready |=> rsp_valid || !req_ready); // R4

   AST_FAULT_ONLY_ON_WALK: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_fault |-> rsp_valid && !rsp_tlb_hit); // R5

   AST_HIT_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_tlb_hit |-> stat_hits == $past(stat_hits) + 1'b1); // R9

   AST_MISS_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && !rsp_tlb_hit |-> stat_misses == $past(stat_misses) + 1'b1); // R9

   AST_COUNTS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid |-> $stable(stat_hits) && $stable(stat_misses)); // R10

endmodule

bind xlat_tlb xlat_tlb_chk #(
   .VA_W(VA_W), .PA_W(PA_W), .PAGE_OFS_W(PAGE_OFS_W), .STAT_W(STAT_W)
) u_chk (.*);

// File: tb/tb_xlat_tlb.sv
module tb_xlat_tlb;
   localparam int CLK_PERIOD = 10;
   localparam int LAT = 3;
   localparam int N = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pt_wr_en = 1'b0, pt_wr_valid = 1'b0;
   logic [3:0]  pt_wr_vpn = '0, pt_wr_ppn = '0;
   logic        req_valid = 1'b0, req_ready;
   logic [15:0] req_vaddr = '0;
   logic        rsp_valid, rsp_fault, rsp_tlb_hit;
   logic [15:0] rsp_paddr, stat_hits, stat_misses;

   xlat_tlb #(.TLB_ENTRIES(N), .WALK_LAT(LAT)) dut (
      .clk(clk), .rst_n(rst_n),
      .pt_wr_en(pt_wr_en), .pt_wr_vpn(pt_wr_vpn), .pt_wr_valid(pt_wr_valid), .pt_wr_ppn(pt_wr_ppn),
      .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
      .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault), .rsp_tlb_hit(rsp_tlb_hit),
      .stat_hits(stat_hits), .stat_misses(stat_misses)
   );

   always #(CLK_PERIOD / 2) clk = ~clk;

   int  n_chk = 0, n_bad = 0;
   bit  done_flag = 0;
   bit  m_vld [16];
   int  m_ppn [16];
   int  lru [$];
   int  m_hits = 0, m_misses = 0;

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done_flag) begin
         done_flag = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   task automatic pt_write(input int v, input bit vld, input int p);
      @(negedge clk);
      pt_wr_en = 1; pt_wr_vpn = 4'(v); pt_wr_valid = vld; pt_wr_ppn = 4'(p);
      @(negedge clk);
      pt_wr_en = 0;
      m_vld[v] = vld; m_ppn[v] = p;
   endtask

   // one translation; optional table write landing on the walk's last edge,
   // optional extra request driven while the walk is busy
   task automatic access(input logic [15:0] va, input bit wr_end, input bit wr_vld,
                         input int wr_ppn, input bit poke);
      int  vpn = int'(va[15:12]);
      int  pos = -1;
      int  k;
      bit  exp_hit, exp_fault;
      int  exp_lat;
      foreach (lru[i]) if (lru[i] == vpn) pos = i;
      exp_hit   = (pos >= 0);
      exp_fault = !exp_hit && !m_vld[vpn];
      exp_lat   = exp_hit ? 1 : LAT + 1;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1; req_vaddr = va;
      @(negedge clk);
      req_valid = 0;
      k = 1;
      if (!exp_hit) chk(!req_ready, "R4", "ready during walk", int'(req_ready), 0);
      while (!rsp_valid && k < 20) begin
         if (poke && k == 1) begin req_valid = 1; req_vaddr = va ^ 16'h5000; end
         if (wr_end && k == LAT) begin
            pt_wr_en = 1; pt_wr_vpn = 4'(vpn); pt_wr_valid = wr_vld; pt_wr_ppn = 4'(wr_ppn);
         end
         @(negedge clk);
         k++;
         req_valid = 0;
         pt_wr_en = 0;
      end
      chk(k == exp_lat, exp_hit ? "R3" : "R4", "response latency", k, exp_lat);
      chk(rsp_tlb_hit == exp_hit, "R7", "hit flag", int'(rsp_tlb_hit), int'(exp_hit));
      chk(rsp_fault == exp_fault, "R5", "fault flag", int'(rsp_fault), int'(exp_fault));
      if (!exp_fault)
         chk(rsp_paddr == {4'(m_ppn[vpn]), va[11:0]}, "R2", "physical address",
             int'(rsp_paddr), int'({4'(m_ppn[vpn]), va[11:0]}));
      if (exp_hit) begin
         lru.delete(pos); lru.push_front(vpn); m_hits++;
      end else begin
         m_misses++;
         if (m_vld[vpn]) begin       // R6 install
            lru.push_front(vpn);
            if (lru.size() > N) void'(lru.pop_back());
         end
      end
      if (wr_end) begin m_vld[vpn] = wr_vld; m_ppn[vpn] = wr_ppn; end
      @(negedge clk);
      chk(!rsp_valid, "R3", "single-cycle pulse", int'(rsp_valid), 0);
      if (poke) begin
         repeat (LAT + 2) begin
            chk(!rsp_valid, "R10", "no response to busy request", int'(rsp_valid), 0);
            @(negedge clk);
         end
      end
      chk(stat_hits == 16'(m_hits), "R9", "hit counter", int'(stat_hits), m_hits);
      chk(stat_misses == 16'(m_misses), "R9", "miss counter", int'(stat_misses), m_misses);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      int unsigned lcg = 32'h1234_5678;
      for (int v = 0; v < 16; v++) begin m_vld[v] = 0; m_ppn[v] = 0; end
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk(!rsp_valid && !rsp_fault && !rsp_tlb_hit, "R1", "response idle after reset",
          int'({rsp_valid, rsp_fault, rsp_tlb_hit}), 0);
      chk(req_ready, "R1", "ready after reset", int'(req_ready), 1);
      chk(stat_hits == 0 && stat_misses == 0, "R1", "counters after reset",
          int'(stat_hits) + int'(stat_misses), 0);
      access(16'h5123, 0, 0, 0, 0);   // R1 empty table faults
      // R8 load table
      for (int v = 0; v < 16; v++) pt_write(v, (v % 5) != 2, (v * 7 + 3) % 16);
      // first sweep: every page misses; second sweep: recency decides
      for (int v = 0; v < 16; v++) access(16'(v << 12) | 16'(v * 273), 0, 0, 0, 0);
      for (int v = 15; v >= 0; v--) access(16'(v << 12) | 16'(v * 37), 0, 0, 0, 0);
      // R6 repeat the same page back to back
      access(16'h3abc, 0, 0, 0, 0);
      access(16'h3def, 0, 0, 0, 0);
      // R7 pseudo-random mix with a hot set to produce hits and evictions
      for (int n = 0; n < 400; n++) begin
         int v;
         lcg = lcg * 32'd1103515245 + 32'd12345;
         v = lcg[20] ? int'(lcg[18:17]) + 8 : int'(lcg[27:24]);
         access({4'(v), lcg[11:0] ^ lcg[30:19]}, 0, 0, 0, 0);
      end
      // R8 write collides with the walk's final cycle: old (invalid) entry used
      access(16'h7abc, 1, 1, 9, 0);
      access(16'h7abc, 0, 0, 0, 0);
      // R10 request during a walk is ignored
      access(16'hc456, 0, 0, 0, 1);
      access(16'hc456, 0, 0, 0, 1);
      finish_run();
   end

endmodule